// File: doc/BRIEF.md
# Multi-Source Interrupt Aggregator

This block gathers up to eight interrupt events raised by the functions of a radio transceiver and presents them to a host processor. It has one active-low request line and a status word with one bit per source. Each source has an enable qualifier. An event is recognised only while that enable is high, and it then sets the source's status bit at the next clock edge. The request line goes low while any status bit is set and returns high once all of them are clear.

The sources do not share one clearing scheme. Each source follows one of three rules, chosen per bit by parameter masks:

- **Read-cleared.** The source is latched and cleared by a read of the status word. A power-on source of this kind also comes out of reset already set.
- **Access-cleared.** The source is latched and cleared by its own data-access strobe, or by its enable being switched off.
- **Level-following.** The source latches nothing. It mirrors a pin level one cycle late while its mode-select (enable) bit is high.

A new event always wins over a clear that arrives in the same cycle, so no event is lost. The serial shifting of the status word is handled outside this block.

Top module: `irq_aggregator`

## Requirements
- R1: During and after reset, before any other input acts, status_o equals the reset-set mask (bit 2, the power-on source, high; all other bits low) and irq_n_o is low.
- R2: When evt_i[k] and en_i[k] are both high at a clock edge, status_o[k] reads high after that edge. An event arriving while en_i[k] is low is ignored and leaves status_o[k] low.
- R3: irq_n_o is low whenever any bit of status_o is high. It is high only when every bit of status_o is low.
- R4: The read-cleared sources (bits 2, 3, 5, 6 and 7 by default) are cleared by stat_rd_i at a clock edge. A status read leaves the access-cleared sources unchanged.
- R5: A recognised event in the same cycle as a clear (a status read or a data access) leaves that status bit set.
- R6: The access-cleared sources (bits 0 and 1 by default) are cleared only by their own ack_i[k] pulse, not by a status read.
- R7: An access-cleared source whose en_i[k] is low at a clock edge reads low after that edge.
- R8: The level-following source (bit 4 by default) reads en_i[4] AND evt_i[4] as sampled at the previous edge. It holds no state, and stat_rd_i and ack_i[4] have no effect on it.
- R9: A latched read-cleared bit stays set when its enable drops. The enable gates only new events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N | Per-source event pulses; the pin level for level-following sources |
| en_i | input | N | Per-source enable; the mode select for level-following sources |
| ack_i | input | N | Per-source data-access strobe that clears access-cleared sources |
| stat_rd_i | input | 1 | Status-read strobe that clears read-cleared sources |
| irq_n_o | output | 1 | Active-low interrupt request line |
| status_o | output | N | Status word, one bit per source |

## Verification
The bench goes after collisions between clears and new events. A design that let a clear win would drop an event raised in the same cycle as a status read or a data access. It also checks that each clear reaches only the sources of its own rule: a design that routed the status read to every bit would wipe pending data-access interrupts, and one that ignored the enable-off clear would leave a dead transmitter's request hanging. Further checks confirm that the level-following bit drops as soon as its pin releases, where a design that latched it would keep the request line low. Long random runs compare the status word and the request line against a bench model on every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [1:0] {
      RULE_READ   = 2'd0,
      RULE_ACCESS = 2'd1,
      RULE_LEVEL  = 2'd2
   } clr_rule_e;

   function automatic clr_rule_e rule_of(input int idx,
                                         input logic [31:0] acc_mask,
                                         input logic [31:0] lvl_mask);
      if (lvl_mask[idx])      return RULE_LEVEL;
      else if (acc_mask[idx]) return RULE_ACCESS;
      else                    return RULE_READ;
   endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
   parameter logic RST_VAL   = 1'b0,
   parameter logic LATCH     = 1'b1,
   parameter logic USE_RD    = 1'b1,
   parameter logic USE_ACK   = 1'b0,
   parameter logic GATE_HOLD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic en_i,
   input  logic rd_i,
   input  logic ack_i,
   output logic flag_o
);

   logic flag_q;
   logic keep;

   always_comb begin
      keep = LATCH & flag_q;
      keep = keep & ~(USE_RD & rd_i);
      keep = keep & ~(USE_ACK & ack_i);
      keep = keep & (~GATE_HOLD | en_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= RST_VAL;
      else        flag_q <= set_i | keep;
   end

   assign flag_o = flag_q;

   // a recognised event is never lost to a clear in the same cycle
   assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
   parameter int N = 8
) (
   input  logic [N-1:0] flags_i,
   output logic         req_n_o
);

   logic [N:0] chain;

   assign chain[0] = 1'b1;
   for (genvar k = 0; k < N; k++) begin : g_and
      assign chain[k+1] = chain[k] & ~flags_i[k];
   end
   assign req_n_o = chain[N];

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int         N           = 8,
   parameter logic [N-1:0] ACCESS_MASK = 8'b0000_0011,
   parameter logic [N-1:0] LEVEL_MASK  = 8'b0001_0000,
   parameter logic [N-1:0] RESET_SET   = 8'b0000_0100
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] en_i,
   input  logic [N-1:0] ack_i,
   input  logic         stat_rd_i,
   output logic         irq_n_o,
   output logic [N-1:0] status_o
);
   import irq_agg_pkg::*;

   localparam logic [31:0] ACC_W = 32'(ACCESS_MASK);
   localparam logic [31:0] LVL_W = 32'(LEVEL_MASK);

   if (N < 1 || N > 32) begin : g_bad_n
      $error("irq_aggregator: N must lie in 1..32");
   end
   if ((ACCESS_MASK & LEVEL_MASK) != '0) begin : g_bad_overlap
      $error("irq_aggregator: a source cannot be both access-cleared and level");
   end
   if ((RESET_SET & (ACCESS_MASK | LEVEL_MASK)) != '0) begin : g_bad_rst
      $error("irq_aggregator: only read-cleared sources may come out of reset set");
   end

   logic [N-1:0] set_v;
   logic [N-1:0] flags;

   assign set_v = evt_i & en_i;

   for (genvar k = 0; k < N; k++) begin : g_src
      localparam clr_rule_e RULE = rule_of(k, ACC_W, LVL_W);

      if (RULE == RULE_LEVEL) begin : g_level
         irq_src_cell #(.RST_VAL(1'b0), .LATCH(1'b0), .USE_RD(1'b0),
                        .USE_ACK(1'b0), .GATE_HOLD(1'b0)) cell_i (
            .clk(clk), .rst_n(rst_n), .set_i(set_v[k]), .en_i(en_i[k]),
            .rd_i(stat_rd_i), .ack_i(ack_i[k]), .flag_o(flags[k]));

         assert_level_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i[k] && evt_i[k]) |=> status_o[k]);
         assert_level_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(en_i[k] && evt_i[k]) |=> !status_o[k]);
      end else if (RULE == RULE_ACCESS) begin : g_access
         irq_src_cell #(.RST_VAL(1'b0), .LATCH(1'b1), .USE_RD(1'b0),
                        .USE_ACK(1'b1), .GATE_HOLD(1'b1)) cell_i (
            .clk(clk), .rst_n(rst_n), .set_i(set_v[k]), .en_i(en_i[k]),
            .rd_i(stat_rd_i), .ack_i(ack_i[k]), .flag_o(flags[k]));

         assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[k] && !evt_i[k]) |=> !status_o[k]);
         assert_off_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i[k] |=> !status_o[k]);
         assert_read_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[k] && en_i[k] && !ack_i[k]) |=> status_o[k]);
      end else begin : g_read
         irq_src_cell #(.RST_VAL(RESET_SET[k]), .LATCH(1'b1), .USE_RD(1'b1),
                        .USE_ACK(1'b0), .GATE_HOLD(1'b0)) cell_i (
            .clk(clk), .rst_n(rst_n), .set_i(set_v[k]), .en_i(en_i[k]),
            .rd_i(stat_rd_i), .ack_i(ack_i[k]), .flag_o(flags[k]));

         assert_rd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_rd_i && !(en_i[k] && evt_i[k])) |=> !status_o[k]);
         assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[k] && !stat_rd_i) |=> status_o[k]);
      end

      assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!status_o[k] && !en_i[k]) |=> !status_o[k]);
   end

   irq_req_merge #(.N(N)) merge_i (
      .flags_i(flags),
      .req_n_o(irq_n_o)
   );

   assign status_o = flags;

   assert_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o != '0) |-> !irq_n_o);

endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam logic [7:0] ACC_M = 8'b0000_0011;
   localparam logic [7:0] LVL_M = 8'b0001_0000;
   localparam logic [7:0] RST_M = 8'b0000_0100;
   localparam logic [7:0] RD_M  = ~(ACC_M | LVL_M);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] evt_i = '0, en_i = '0, ack_i = '0;
   logic stat_rd_i = 1'b0;
   logic irq_n_o;
   logic [N-1:0] status_o;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_st;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_aggregator #(.N(N), .ACCESS_MASK(ACC_M), .LEVEL_MASK(LVL_M),
                    .RESET_SET(RST_M)) dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_i(en_i), .ack_i(ack_i),
      .stat_rd_i(stat_rd_i), .irq_n_o(irq_n_o), .status_o(status_o));

   function automatic logic [7:0] model_next(input logic [7:0] cur,
      input logic [7:0] ev, input logic [7:0] en, input logic [7:0] ak,
      input logic rd);
      logic [7:0] set_b, keep_rd, keep_acc;
      set_b    = ev & en;
      keep_rd  = cur & RD_M & ~{8{rd}};
      keep_acc = cur & ACC_M & en & ~ak;
      return set_b | keep_rd | keep_acc;
   endfunction

   task automatic chk(input logic ok, input string req,
                      input logic [7:0] act, input logic [7:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, expv);
      end
   endtask

   task automatic step(input logic [7:0] ev, input logic [7:0] en,
                       input logic [7:0] ak, input logic rd, input string req);
      exp_st = model_next(exp_st, ev, en, ak, rd);
      evt_i = ev; en_i = en; ack_i = ak; stat_rd_i = rd;
      @(negedge clk);
      chk(status_o == exp_st, req, status_o, exp_st);
      chk(irq_n_o == (exp_st == 8'h00), "R3 request line",
          {7'b0, irq_n_o}, {7'b0, exp_st == 8'h00});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int seed_unused;
      seed_unused = $urandom(32'h5eed_1234);
      repeat (2) @(negedge clk);
      // R1 reset state
      chk(status_o == RST_M, "R1 reset status", status_o, RST_M);
      chk(irq_n_o == 1'b0, "R1 reset line", {7'b0, irq_n_o}, 8'h00);
      rst_n = 1'b1;
      exp_st = RST_M;
      @(negedge clk);
      chk(status_o == RST_M, "R1 after release", status_o, RST_M);

      step(8'h00, 8'h00, 8'h00, 1'b1, "R4 read clears power-on bit");
      step(8'h08, 8'h00, 8'h00, 1'b0, "R2 disabled event ignored");
      step(8'h00, 8'hFF, 8'h00, 1'b0, "R2 ignored event left nothing");
      step(8'h08, 8'hFF, 8'h00, 1'b0, "R2 enabled event sets");
      step(8'h20, 8'hFF, 8'h00, 1'b1, "R5 event beside read survives");
      step(8'h00, 8'hFF, 8'h00, 1'b1, "R4 read clears");
      step(8'h01, 8'hFF, 8'h00, 1'b0, "R2 access source sets");
      step(8'h00, 8'hFF, 8'h00, 1'b1, "R6 read leaves access bit");
      step(8'h00, 8'hFF, 8'h01, 1'b0, "R6 ack clears access bit");
      step(8'h01, 8'hFF, 8'h01, 1'b0, "R5 event beside ack survives");
      step(8'h00, 8'hFF, 8'h01, 1'b0, "R6 ack clears");
      step(8'h02, 8'hFF, 8'h00, 1'b0, "R2 overrun bit sets");
      step(8'h00, 8'hFD, 8'h00, 1'b0, "R7 enable off clears access bit");
      step(8'h40, 8'hFF, 8'h00, 1'b0, "R2 spare bit sets");
      step(8'h00, 8'hBF, 8'h00, 1'b0, "R9 read-cleared bit holds");
      step(8'h00, 8'hFF, 8'h00, 1'b1, "R4 read clears held bit");
      step(8'h10, 8'hFF, 8'h00, 1'b0, "R8 level high");
      step(8'h10, 8'hFF, 8'h10, 1'b1, "R8 level ignores read and ack");
      step(8'h00, 8'hFF, 8'h00, 1'b0, "R8 level drops with pin");
      step(8'h10, 8'hEF, 8'h00, 1'b0, "R8 mode off ignores pin");

      for (int i = 0; i < 3000; i++) begin
         logic [7:0] ev, en, ak;
         logic rd;
         ev = $urandom() & $urandom();
         en = $urandom() | $urandom() | $urandom();
         ak = $urandom() & $urandom() & $urandom();
         rd = ($urandom() % 8) == 0;
         step(ev, en, ak, rd, "R2 R4 R6 R7 R8 R9 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule